// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Interpreter

This block is a synthesizable device-side model of a byte-wide NOR flash. It watches the active-low chip enable, output enable and write enable strobes together with a 17-bit address and an 8-bit data bus. It turns the write cycles it sees into command sequences, and it carries out array reads, identification reads, byte programming, sector erase and reset. The storage array is kept small by a parameter. Each 16 KB sector is represented by a short window of bytes, so the model stays cheap while the command behaviour stays whole.

Commands are accepted only behind a two-write unlock pair. Program and erase run for a parameterised number of clock cycles. During that time a read returns a status byte instead of array data, and a program that tries to turn a 0 bit back into 1 leaves the device in a failed state that only a reset command clears. The strobes are assumed to be synchronous to `clk` and are sampled on its rising edge.

Top module: `flash_cmd_unit`

## Requirements
- R1: After `rstN` is released every array byte reads 0xFF and the device is in array-read mode. `dqOe` is 1 only while `ceN`=0, `oeN`=0 and `weN`=1. In array-read mode `dqOut` is the byte stored at index {addr[16:14], addr[OFFS_W-1:0]}.
- R2: A write cycle spans the time both `ceN` and `weN` are low. The address is taken when the later of the two falls, and the data is taken when the first of the two rises.
- R3: A command is decoded only after 0xAA is written to an address whose low 15 bits are 0x5555, followed by 0x55 to 0x2AAA. The third write, to 0x5555, selects the command: 0xF0 reset, 0x90 identification, 0xA0 program, 0x80 erase setup.
- R4: In array-read, identification, unlock-pending or failed state, one write of 0xF0 to any address returns the device to array-read mode.
- R5: In identification mode a read with addr[7:0]=0x00 returns 0x01, addr[7:0]=0x01 returns 0x20, and any other offset returns 0x00.
- R6: The write that follows the program command programs its address. After PROG_CYCLES cycles the byte holds old AND data.
- R7: Erase setup, then a second unlock pair, then 0x30 written anywhere in a sector (sector = addr[16:14]) sets every byte of that sector to 0xFF after ERASE_CYCLES cycles. Other sectors are unchanged.
- R8: While a program is busy a read returns DQ7 = complement of bit 7 of the programmed data, with DQ5, DQ3 and DQ2..DQ0 at 0 and DQ4 at 0.
- R9: In any status state (program busy, erase busy, failed), DQ6 inverts between one read access and the next.
- R10: While an erase is busy a read returns DQ7=0, DQ3=1 and DQ5=0.
- R11: Writes made while a program or erase is busy are ignored, including 0xF0.
- R12: A program whose data has a 1 where the old byte has a 0 completes into a failed state. Reads there return DQ5=1 and DQ7 = complement of bit 7 of the data until 0xF0 is written. The array byte still becomes old AND data.
- R13: A write that does not fit the expected next step of a sequence returns the interpreter to array-read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset, array to 0xFF, read mode |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| addr | input | 17 | Byte address |
| dqIn | input | 8 | Data written by the host |
| dqOut | output | 8 | Data or status driven to the host |
| dqOe | output | 1 | High while the device drives `dqOut` |

## Verification
A wrong interpreter state shows up at the ports on the very next read. An identification read gives 0x01 where 0xFF was due, a status byte appears where array data belonged, or the reverse. A mis-timed or mis-applied program or erase only shows once the busy window has closed, so the bench reads the target byte a few cycles after the nominal end, and also reads a neighbouring sector. A stuck DQ6 is caught by comparing two back-to-back status reads.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int FLASH_AW = 17;
  localparam int SECT_LSB = 14;
  localparam int SECT_W = FLASH_AW - SECT_LSB;

  typedef enum logic [2:0] {
    RM_ARRAY, RM_ID, RM_PROG, RM_ERASE, RM_FAIL
  } readMode_t;

  typedef struct packed {
    logic doProgram;
    logic doErase;
    readMode_t rdMode;
    logic [FLASH_AW-1:0] tgtAddr;
    logic [7:0] tgtData;
  } ctrlStrobes_t;
endpackage

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYCLES = 16,
  parameter int ERASE_CYCLES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic weN,
  input  logic [FLASH_AW-1:0] addr,
  input  logic [7:0] dqIn,
  input  logic progConflict,
  output ctrlStrobes_t strb
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  typedef enum logic [3:0] {
    S_READ, S_ID, S_UNL1, S_UNL2, S_PGM, S_ESET, S_EUNL1, S_EUNL2,
    S_BPROG, S_BERASE, S_FAIL
  } cmdState_t;

  cmdState_t state, stateNext;
  logic wrAct, wrActQ, wrCommit;
  logic [FLASH_AW-1:0] latchAddr;
  logic [CNT_W-1:0] busyCnt;
  logic [FLASH_AW-1:0] tgtAddr;
  logic [7:0] tgtData;
  logic isUnl1, isUnl2, atCmdAddr, isReset, busy;

  assign wrAct = !ceN && !weN;
  assign wrCommit = wrActQ && !wrAct;
  assign atCmdAddr = latchAddr[14:0] == 15'h5555;
  assign isUnl1 = atCmdAddr && dqIn == 8'hAA;
  assign isUnl2 = latchAddr[14:0] == 15'h2AAA && dqIn == 8'h55;
  assign isReset = dqIn == 8'hF0;
  assign busy = state == S_BPROG || state == S_BERASE;

  // Bus sampling: address on start of write overlap, data on its end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ <= 1'b0;
      latchAddr <= '0;
    end else begin
      wrActQ <= wrAct;
      if (wrAct && !wrActQ) latchAddr <= addr;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_READ, S_ID: if (wrCommit) begin
        if (isReset) stateNext = S_READ;
        else if (isUnl1) stateNext = S_UNL1;
        else stateNext = S_READ;
      end
      S_FAIL: if (wrCommit && isReset) stateNext = S_READ;
      S_UNL1: if (wrCommit) stateNext = isUnl2 ? S_UNL2 : S_READ;
      S_UNL2: if (wrCommit) begin
        stateNext = S_READ;
        if (atCmdAddr) begin
          case (dqIn)
            8'h90: stateNext = S_ID;
            8'hA0: stateNext = S_PGM;
            8'h80: stateNext = S_ESET;
            default: stateNext = S_READ;
          endcase
        end
      end
      S_PGM: if (wrCommit) stateNext = S_BPROG;
      S_ESET: if (wrCommit) stateNext = isUnl1 ? S_EUNL1 : S_READ;
      S_EUNL1: if (wrCommit) stateNext = isUnl2 ? S_EUNL2 : S_READ;
      S_EUNL2: if (wrCommit) stateNext = (dqIn == 8'h30) ? S_BERASE : S_READ;
      S_BPROG: if (busyCnt == '0) stateNext = progConflict ? S_FAIL : S_READ;
      S_BERASE: if (busyCnt == '0) stateNext = S_READ;
      default: stateNext = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_READ;
      busyCnt <= '0;
      tgtAddr <= '0;
      tgtData <= '0;
    end else begin
      state <= stateNext;
      if (busy && busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      if (wrCommit && state == S_PGM) begin
        busyCnt <= CNT_W'(PROG_CYCLES - 1);
        tgtAddr <= latchAddr;
        tgtData <= dqIn;
      end
      if (wrCommit && state == S_EUNL2) begin
        busyCnt <= CNT_W'(ERASE_CYCLES - 1);
        tgtAddr <= latchAddr;
      end
    end
  end

  always_comb begin
    strb.doProgram = state == S_BPROG && busyCnt == '0;
    strb.doErase = state == S_BERASE && busyCnt == '0;
    strb.tgtAddr = tgtAddr;
    strb.tgtData = tgtData;
    unique case (state)
      S_ID: strb.rdMode = RM_ID;
      S_BPROG: strb.rdMode = RM_PROG;
      S_BERASE: strb.rdMode = RM_ERASE;
      S_FAIL: strb.rdMode = RM_FAIL;
      default: strb.rdMode = RM_ARRAY;
    endcase
  end

  // R3: full unlock plus 0xA0 arms programming
  a_r3_prog_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_UNL2 && wrCommit && atCmdAddr && dqIn == 8'hA0) |=> state == S_PGM);
  // R11: mid-busy cycles keep the busy state whatever is written
  a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyCnt != '0) |=> state == $past(state));
  // R12: failed state is left only through a 0xF0 write
  a_r12_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FAIL && !(wrCommit && isReset)) |=> state == S_FAIL);
  // R13: a broken unlock falls back to array read
  a_r13_bad_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_UNL1 && wrCommit && !isUnl2) |=> state == S_READ);
endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
  import flash_cmd_pkg::*;
#(
  parameter int OFFS_W = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic oeN,
  input  logic weN,
  input  logic [FLASH_AW-1:0] addr,
  input  ctrlStrobes_t strb,
  output logic progConflict,
  output logic [7:0] dqOut,
  output logic dqOe
);
  localparam int IDX_W = SECT_W + OFFS_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int SECT_BYTES = 1 << OFFS_W;

  logic [7:0] mem [DEPTH];
  logic [IDX_W-1:0] rdIdx, tgtIdx;
  logic [SECT_W-1:0] eraseSec;
  logic rdAct, rdActQ, toggleBit, statusMode;
  logic [7:0] oldByte, statusByte;

  assign rdIdx = {addr[FLASH_AW-1:SECT_LSB], addr[OFFS_W-1:0]};
  assign tgtIdx = {strb.tgtAddr[FLASH_AW-1:SECT_LSB], strb.tgtAddr[OFFS_W-1:0]};
  assign eraseSec = strb.tgtAddr[FLASH_AW-1:SECT_LSB];
  assign oldByte = mem[tgtIdx];
  assign progConflict = |(strb.tgtData & ~oldByte);

  assign rdAct = !ceN && !oeN && weN;
  assign dqOe = rdAct;
  assign statusMode = strb.rdMode == RM_PROG || strb.rdMode == RM_ERASE ||
                      strb.rdMode == RM_FAIL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActQ <= 1'b0;
      toggleBit <= 1'b0;
    end else begin
      rdActQ <= rdAct;
      if (rdActQ && !rdAct && statusMode) toggleBit <= !toggleBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (strb.doProgram) mem[tgtIdx] <= oldByte & strb.tgtData;
      if (strb.doErase) begin
        for (int i = 0; i < DEPTH; i++)
          if ((i / SECT_BYTES) == int'(eraseSec)) mem[i] <= 8'hFF;
      end
    end
  end

  always_comb begin
    statusByte = '0;
    statusByte[6] = toggleBit;
    unique case (strb.rdMode)
      RM_PROG: statusByte[7] = !strb.tgtData[7];
      RM_ERASE: statusByte[3] = 1'b1;
      RM_FAIL: begin
        statusByte[7] = !strb.tgtData[7];
        statusByte[5] = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (strb.rdMode)
      RM_ID: begin
        if (addr[7:0] == 8'h00) dqOut = 8'h01;
        else if (addr[7:0] == 8'h01) dqOut = 8'h20;
        else dqOut = 8'h00;
      end
      RM_PROG, RM_ERASE, RM_FAIL: dqOut = statusByte;
      default: dqOut = mem[rdIdx];
    endcase
  end

  // R9: each finished status read flips DQ6
  a_r9_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (rdActQ && !rdAct && statusMode) |=> toggleBit != $past(toggleBit));
  // R6: programming can only clear bits
  a_r6_and_only: assert property (@(posedge clk) disable iff (!rstN)
    strb.doProgram |=> mem[$past(tgtIdx)] == ($past(oldByte) & $past(strb.tgtData)));
  // R7: erase leaves the first byte of the sector at 0xFF
  a_r7_erase_ff: assert property (@(posedge clk) disable iff (!rstN)
    strb.doErase |=> mem[{$past(eraseSec), OFFS_W'(0)}] == 8'hFF);
  // R1: no drive while a write strobe is low
  a_r1_no_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !dqOe);
endmodule

// File: rtl/flash_cmd_unit.sv
module flash_cmd_unit
  import flash_cmd_pkg::*;
#(
  parameter int OFFS_W = 5,
  parameter int PROG_CYCLES = 16,
  parameter int ERASE_CYCLES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic oeN,
  input  logic weN,
  input  logic [16:0] addr,
  input  logic [7:0] dqIn,
  output logic [7:0] dqOut,
  output logic dqOe
);
  ctrlStrobes_t strb;
  logic progConflict;

  fcmd_ctrl #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .addr(addr), .dqIn(dqIn),
    .progConflict(progConflict), .strb(strb)
  );

  fcmd_array #(.OFFS_W(OFFS_W)) u_array (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .strb(strb), .progConflict(progConflict), .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: tb/flash_cmd_unit_tb.sv
module flash_cmd_unit_tb;
  logic clk = 0, rstN = 0, ceN = 1, oeN = 1, weN = 1;
  logic [16:0] addr = '0;
  logic [7:0] dqIn = '0;
  logic [7:0] dqOut;
  logic dqOe;
  int vecCount = 0, missCount = 0;
  bit finished = 0;

  always #5 clk = !clk;

  flash_cmd_unit u_dut (.clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wrCycle(logic [16:0] a, logic [7:0] d);
    @(negedge clk); addr = a; dqIn = d; ceN = 0;
    @(negedge clk); weN = 0;
    @(negedge clk);
    @(negedge clk); weN = 1;
    @(negedge clk); ceN = 1;
  endtask

  task automatic rdCycle(logic [16:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ceN = 0; oeN = 0;
    @(posedge clk); #1 d = dqOut;
    @(negedge clk); oeN = 1; ceN = 1;
  endtask

  task automatic unlock();
    wrCycle(17'h05555, 8'hAA);
    wrCycle(17'h02AAA, 8'h55);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    @(negedge clk); ceN = 0; oeN = 1;
    @(posedge clk); #1 check("R1 no drive with oeN high", {7'd0, dqOe}, 8'h00);
    @(negedge clk); ceN = 1;
    rdCycle(17'h00000, d); check("R1 erased after reset", d, 8'hFF);
    @(negedge clk); ceN = 0; oeN = 0;
    @(posedge clk); #1 check("R1 drive during read", {7'd0, dqOe}, 8'h01);
    @(negedge clk); ceN = 1; oeN = 1;
  endtask

  task automatic testIdentTiming();
    logic [7:0] d;
    // WE# falls last: address moves after it, data settles before rise
    @(negedge clk); addr = 17'h05555; dqIn = 8'h00; ceN = 0;
    @(negedge clk); weN = 0;
    @(negedge clk); addr = 17'h00123; dqIn = 8'hAA;
    @(negedge clk); weN = 1;
    @(negedge clk); ceN = 1;
    // CE# falls last and rises first
    @(negedge clk); addr = 17'h02AAA; dqIn = 8'h55; weN = 0;
    @(negedge clk); ceN = 0;
    @(negedge clk); addr = 17'h00777;
    @(negedge clk); ceN = 1;
    @(negedge clk); weN = 1;
    wrCycle(17'h05555, 8'h90);
    rdCycle(17'h00000, d); check("R2 R3 R5 maker code", d, 8'h01);
    rdCycle(17'h00001, d); check("R5 device code", d, 8'h20);
    rdCycle(17'h00002, d); check("R5 other offset", d, 8'h00);
    rdCycle(17'h04000, d); check("R5 code in sector 1", d, 8'h01);
    wrCycle(17'h01234, 8'hF0);
    rdCycle(17'h00000, d); check("R4 reset leaves ident", d, 8'hFF);
  endtask

  task automatic testProgram();
    logic [7:0] s1, s2, d;
    unlock(); wrCycle(17'h05555, 8'hA0); wrCycle(17'h04003, 8'h5A);
    rdCycle(17'h04003, s1); check("R8 program status", s1 & 8'hBF, 8'h80);
    rdCycle(17'h04003, s2); check("R9 toggle differs", (s1 ^ s2) & 8'h40, 8'h40);
    wrCycle(17'h04003, 8'hF0);
    waitCyc(12);
    rdCycle(17'h04003, d); check("R6 R11 programmed byte", d, 8'h5A);
    unlock(); wrCycle(17'h05555, 8'hA0); wrCycle(17'h04003, 8'h4A);
    waitCyc(20);
    rdCycle(17'h04003, d); check("R6 clear more bits", d, 8'h4A);
    unlock(); wrCycle(17'h05555, 8'hA0); wrCycle(17'h08001, 8'h33);
    waitCyc(20);
  endtask

  task automatic testErase();
    logic [7:0] s1, s2, d;
    unlock(); wrCycle(17'h05555, 8'h80);
    unlock(); wrCycle(17'h04010, 8'h30);
    rdCycle(17'h04003, s1); check("R10 erase status", s1 & 8'hBF, 8'h08);
    rdCycle(17'h04003, s2); check("R9 erase toggle", (s1 ^ s2) & 8'h40, 8'h40);
    waitCyc(36);
    rdCycle(17'h04003, d); check("R7 sector erased", d, 8'hFF);
    rdCycle(17'h08001, d); check("R7 other sector kept", d, 8'h33);
  endtask

  task automatic testFail();
    logic [7:0] s1, s2, d;
    unlock(); wrCycle(17'h05555, 8'hA0); wrCycle(17'h04005, 8'h0F);
    waitCyc(20);
    unlock(); wrCycle(17'h05555, 8'hA0); wrCycle(17'h04005, 8'hF0);
    waitCyc(20);
    rdCycle(17'h04005, s1); check("R12 fail status", s1 & 8'hBF, 8'h20);
    wrCycle(17'h05555, 8'hAA);
    rdCycle(17'h04005, s2); check("R12 fail persists", s2 & 8'hBF, 8'h20);
    check("R9 fail toggle", (s1 ^ s2) & 8'h40, 8'h40);
    wrCycle(17'h00000, 8'hF0);
    rdCycle(17'h04005, d); check("R12 R4 byte after fail", d, 8'h00);
  endtask

  task automatic testMismatch();
    logic [7:0] d;
    wrCycle(17'h05555, 8'hAA); wrCycle(17'h02AAB, 8'h55); wrCycle(17'h05555, 8'h90);
    rdCycle(17'h00000, d); check("R13 wrong unlock address", d, 8'hFF);
    unlock(); wrCycle(17'h05555, 8'h77); wrCycle(17'h05555, 8'h90);
    rdCycle(17'h00000, d); check("R13 unknown command", d, 8'hFF);
    unlock(); wrCycle(17'h05555, 8'h80); unlock(); wrCycle(17'h08000, 8'h31);
    rdCycle(17'h08001, d); check("R13 bad erase confirm", d, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testIdentTiming();
    testProgram();
    testErase();
    testFail();
    testMismatch();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end
endmodule